// File: doc/BRIEF.md
# Timer and External Interrupt Control Register

This block is one byte-wide special-function register for a small 8-bit microcontroller. It holds the run enables for two timers and latches their overflow events as interrupt flags. It also watches two external interrupt pins. For each pin, software chooses edge or level sensitivity, and a polarity input from outside the register chooses whether the pin is active high or active low. The CPU reaches the register through a byte port and a single-bit port. It clears a flag either by writing it or by pulsing the acknowledge strobe for that source when it vectors to the handler.

Each interrupt request output mirrors its flag bit. The timers, the priority logic and the CPU sit outside this block.

Top module: `tmrx_ctl`

## Requirements
- R1: After reset every register bit is 0, so all run enables, all interrupt requests and the read data are 0.
- R2: The register answers only when `sfr_addr` equals 0x88 and `sfr_page` equals 0. A byte write then loads all eight bits. When not selected, `sfr_rdata` reads 0 and writes have no effect. The bit layout from bit 7 down to bit 0 is: timer 1 overflow flag, timer 1 run, timer 0 overflow flag, timer 0 run, external 1 flag, external 1 mode, external 0 flag, external 0 mode.
- R3: A bit write loads `sfr_bit_val` into bit `sfr_bit_sel` only, and leaves the other seven bits unchanged. If a byte write and a bit write arrive together, the byte write is used.
- R4: `tmr_run[i]` equals the timer i run bit, which changes only through writes.
- R5: A pulse on `tmr_ovf[i]` sets the timer i overflow flag at the next clock edge. Writing 0 to the flag clears it, and so does a pulse on `ack_tmr[i]`.
- R6: A hardware set of any flag in the same cycle as a software clear or an acknowledge leaves the flag set.
- R7: Each pin passes through two flops. In edge mode (mode bit = 1), a change from inactive to active between consecutive synchronized samples sets the flag. The flag is visible after the third rising edge following the pin change, and a pin held active does not set it again.
- R8: In edge mode, an `ack_ext[i]` pulse or a write of 0 clears the external flag.
- R9: In level mode (mode bit = 0), the external flag equals the synchronized active level at the same three-edge latency. Acknowledges and writes to the flag bit have no effect on it.
- R10: `ext_pol[i]` = 1 makes pin i active high, and `ext_pol[i]` = 0 makes it active low.
- R11: `irq_tmr[i]` and `irq_ext[i]` always equal their flag bits as read back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sfr_addr | input | 8 | Register address |
| sfr_page | input | 4 | Register page |
| sfr_wr | input | 1 | Byte write strobe |
| sfr_wdata | input | 8 | Byte write data |
| sfr_bit_wr | input | 1 | Single-bit write strobe |
| sfr_bit_sel | input | 3 | Bit index for a bit write |
| sfr_bit_val | input | 1 | Value for a bit write |
| sfr_rdata | output | 8 | Read data, 0 when not selected |
| tmr_ovf | input | 2 | Timer overflow pulses |
| ack_tmr | input | 2 | Timer interrupt acknowledge strobes |
| ext_pin | input | 2 | External interrupt pins (asynchronous) |
| ext_pol | input | 2 | Pin polarity, 1 = active high |
| ack_ext | input | 2 | External interrupt acknowledge strobes |
| tmr_run | output | 2 | Timer run enables |
| irq_tmr | output | 2 | Timer interrupt requests |
| irq_ext | output | 2 | External interrupt requests |

## Verification
The bench drives an overflow or a detected edge in the same cycle as a software clear or an acknowledge. A design that let the clear win would drop the event and leave the request low.

It holds a pin active after acknowledging an edge-mode flag. A design that treated edge mode as a level would set the flag again.

In level mode it tries to clear the flag by writing and by acknowledging while the pin stays active. A design that honoured either would show a request that drops while the pin is asserted.

It also counts the latency of the pin synchronizer and checks addresses and pages that do not match. A design with a missing or extra flop would shift the flag by a cycle, and one that decoded only the address would take writes meant for other registers.

// File: rtl/tmrx_pkg.sv
package tmrx_pkg;

  localparam int NCH = 2;
  localparam int DW  = 8;

  // Bit positions that software decodes: timer channel i, external channel i
  function automatic int ovf_pos(input int i);
    return 5 + 2 * i;
  endfunction

  function automatic int run_pos(input int i);
    return 4 + 2 * i;
  endfunction

  function automatic int xflag_pos(input int i);
    return 1 + 2 * i;
  endfunction

  function automatic int xmode_pos(input int i);
    return 2 * i;
  endfunction

  // Pin sample adjusted by polarity: result 1 means active
  function automatic logic act_level(input logic smp, input logic pol);
    return pol ? smp : ~smp;
  endfunction

  // Flag update: a hardware set beats clear and write; clear beats write
  function automatic logic flag_next(input logic cur, input logic hw_set,
                                     input logic clr, input logic we,
                                     input logic wv);
    return hw_set | (~clr & (we ? wv : cur));
  endfunction

endpackage

// File: rtl/tmrx_sync.sv
module tmrx_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[k] <= '0;
      else        stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/tmrx_ext_det.sv
module tmrx_ext_det #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] smp,
  input  logic [W-1:0] pol,
  output logic [W-1:0] act,
  output logic [W-1:0] edge_det
);

  // Previous raw sample; polarity is applied to both samples with the current select
  logic [W-1:0] smp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) smp_q <= '0;
    else        smp_q <= smp;
  end

  for (genvar i = 0; i < W; i++) begin : g_ch
    logic prev_act;
    assign act[i]      = tmrx_pkg::act_level(smp[i], pol[i]);
    assign prev_act    = tmrx_pkg::act_level(smp_q[i], pol[i]);
    assign edge_det[i] = act[i] & ~prev_act;
  end

endmodule

// File: rtl/tmrx_ctl.sv
module tmrx_ctl #(
  parameter int                ADDR_W   = 8,
  parameter int                PAGE_W   = 4,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h88,
  parameter logic [PAGE_W-1:0] REG_PAGE = '0,
  parameter int                SYNC_N   = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           sfr_addr,
  input  logic [PAGE_W-1:0]           sfr_page,
  input  logic                        sfr_wr,
  input  logic [tmrx_pkg::DW-1:0]     sfr_wdata,
  input  logic                        sfr_bit_wr,
  input  logic [$clog2(tmrx_pkg::DW)-1:0] sfr_bit_sel,
  input  logic                        sfr_bit_val,
  output logic [tmrx_pkg::DW-1:0]     sfr_rdata,
  input  logic [tmrx_pkg::NCH-1:0]    tmr_ovf,
  input  logic [tmrx_pkg::NCH-1:0]    ack_tmr,
  input  logic [tmrx_pkg::NCH-1:0]    ext_pin,
  input  logic [tmrx_pkg::NCH-1:0]    ext_pol,
  input  logic [tmrx_pkg::NCH-1:0]    ack_ext,
  output logic [tmrx_pkg::NCH-1:0]    tmr_run,
  output logic [tmrx_pkg::NCH-1:0]    irq_tmr,
  output logic [tmrx_pkg::NCH-1:0]    irq_ext
);

  localparam int DW  = tmrx_pkg::DW;
  localparam int NCH = tmrx_pkg::NCH;

  // Named internal events, visible to the bound checker
  logic           sel_hit;
  logic           byte_we;
  logic           wr_hit;
  logic [DW-1:0]  we_vec;
  logic [DW-1:0]  wv_vec;
  logic [NCH-1:0] ext_smp;
  logic [NCH-1:0] ext_act;
  logic [NCH-1:0] ext_edge;
  logic [DW-1:0]  ctl_q;
  logic [DW-1:0]  ctl_d;

  assign sel_hit = (sfr_addr == REG_ADDR) && (sfr_page == REG_PAGE);
  assign byte_we = sel_hit & sfr_wr;
  assign wr_hit  = sel_hit & (sfr_wr | sfr_bit_wr);

  for (genvar b = 0; b < DW; b++) begin : g_wr
    assign we_vec[b] = byte_we |
                       (sel_hit & sfr_bit_wr & (sfr_bit_sel == b[$clog2(DW)-1:0]));
    assign wv_vec[b] = byte_we ? sfr_wdata[b] : sfr_bit_val;
  end

  tmrx_sync #(.W(NCH), .STAGES(SYNC_N)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ext_pin),
    .q     (ext_smp)
  );

  tmrx_ext_det #(.W(NCH)) u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp      (ext_smp),
    .pol      (ext_pol),
    .act      (ext_act),
    .edge_det (ext_edge)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_tmr
    localparam int PO = tmrx_pkg::ovf_pos(i);
    localparam int PR = tmrx_pkg::run_pos(i);
    assign ctl_d[PR] = we_vec[PR] ? wv_vec[PR] : ctl_q[PR];
    assign ctl_d[PO] = tmrx_pkg::flag_next(ctl_q[PO], tmr_ovf[i], ack_tmr[i],
                                           we_vec[PO], wv_vec[PO]);
    assign tmr_run[i] = ctl_q[PR];
    assign irq_tmr[i] = ctl_q[PO];
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ext
    localparam int PF = tmrx_pkg::xflag_pos(i);
    localparam int PM = tmrx_pkg::xmode_pos(i);
    logic edge_mode;
    assign edge_mode = ctl_q[PM];
    assign ctl_d[PM] = we_vec[PM] ? wv_vec[PM] : ctl_q[PM];
    assign ctl_d[PF] = edge_mode
                       ? tmrx_pkg::flag_next(ctl_q[PF], ext_edge[i], ack_ext[i],
                                             we_vec[PF], wv_vec[PF])
                       : ext_act[i];
    assign irq_ext[i] = ctl_q[PF];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  assign sfr_rdata = sel_hit ? ctl_q : '0;

endmodule

// File: rtl/tmrx_ctl_chk.sv
module tmrx_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel_hit,
  input logic       wr_hit,
  input logic [7:0] ctl_q,
  input logic [1:0] ext_act,
  input logic [1:0] ext_edge,
  input logic [1:0] tmr_ovf,
  input logic [1:0] ack_tmr,
  input logic [1:0] tmr_run,
  input logic [1:0] irq_tmr,
  input logic [1:0] irq_ext,
  input logic [7:0] sfr_rdata
);

  // R4
  run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(tmr_run));

  // R2
  rd_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_hit |-> sfr_rdata == {irq_tmr[1], tmr_run[1], irq_tmr[0], tmr_run[0],
                              irq_ext[1], ctl_q[2], irq_ext[0], ctl_q[0]});

  for (genvar i = 0; i < 2; i++) begin : g_ch
    // R6
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_ovf[i] |=> irq_tmr[i]);

    // R5
    ovf_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_tmr[i] && !tmr_ovf[i]) |=> !irq_tmr[i]);

    // R7
    edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_q[2*i] && ext_edge[i]) |=> irq_ext[i]);

    // R9
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_q[2*i] |=> irq_ext[i] == $past(ext_act[i]));
  end

endmodule

bind tmrx_ctl tmrx_ctl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sel_hit   (sel_hit),
  .wr_hit    (wr_hit),
  .ctl_q     (ctl_q),
  .ext_act   (ext_act),
  .ext_edge  (ext_edge),
  .tmr_ovf   (tmr_ovf),
  .ack_tmr   (ack_tmr),
  .tmr_run   (tmr_run),
  .irq_tmr   (irq_tmr),
  .irq_ext   (irq_ext),
  .sfr_rdata (sfr_rdata)
);

// File: tb/tmrx_ctl_bench.sv
module tmrx_ctl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] sfr_addr = 8'h00;
  logic [3:0] sfr_page = 4'h0;
  logic       sfr_wr = 1'b0;
  logic [7:0] sfr_wdata = 8'h00;
  logic       sfr_bit_wr = 1'b0;
  logic [2:0] sfr_bit_sel = 3'd0;
  logic       sfr_bit_val = 1'b0;
  logic [7:0] sfr_rdata;
  logic [1:0] tmr_ovf = 2'b00, ack_tmr = 2'b00, ack_ext = 2'b00;
  logic [1:0] ext_pin = 2'b00, ext_pol = 2'b11;
  logic [1:0] tmr_run, irq_tmr, irq_ext;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Reference model state
  logic [7:0] m_reg = 8'h00;
  logic [1:0] m_s1 = 2'b00, m_s2 = 2'b00, m_s3 = 2'b00;

  always #2.5 clk = ~clk;

  tmrx_ctl u_tmrx_ctl (
    .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_page(sfr_page),
    .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata), .sfr_bit_wr(sfr_bit_wr),
    .sfr_bit_sel(sfr_bit_sel), .sfr_bit_val(sfr_bit_val), .sfr_rdata(sfr_rdata),
    .tmr_ovf(tmr_ovf), .ack_tmr(ack_tmr), .ext_pin(ext_pin), .ext_pol(ext_pol),
    .ack_ext(ack_ext), .tmr_run(tmr_run), .irq_tmr(irq_tmr), .irq_ext(irq_ext)
  );

  function automatic logic hit();
    return sfr_addr == 8'h88 && sfr_page == 4'h0;
  endfunction

  // Model of one clock edge, written from the requirements
  function automatic logic [7:0] model_next();
    logic [7:0] n;
    logic [7:0] we;
    logic [7:0] wv;
    n = m_reg;
    for (int b = 0; b < 8; b++) begin
      we[b] = 1'b0;
      wv[b] = 1'b0;
      if (hit() && sfr_wr) begin
        we[b] = 1'b1; wv[b] = sfr_wdata[b];
      end else if (hit() && sfr_bit_wr && sfr_bit_sel == b) begin
        we[b] = 1'b1; wv[b] = sfr_bit_val;
      end
    end
    for (int i = 0; i < 2; i++) begin
      int fo, ru, xf, xm;
      logic a_now, a_old;
      ru = (i == 0) ? 4 : 6;
      fo = (i == 0) ? 5 : 7;
      xm = (i == 0) ? 0 : 2;
      xf = (i == 0) ? 1 : 3;
      if (we[ru]) n[ru] = wv[ru];
      if (tmr_ovf[i])      n[fo] = 1'b1;
      else if (ack_tmr[i]) n[fo] = 1'b0;
      else if (we[fo])     n[fo] = wv[fo];
      a_now = ext_pol[i] ? m_s2[i] : !m_s2[i];
      a_old = ext_pol[i] ? m_s3[i] : !m_s3[i];
      if (!m_reg[xm])                n[xf] = a_now;
      else if (a_now && !a_old)      n[xf] = 1'b1;
      else if (ack_ext[i])           n[xf] = 1'b0;
      else if (we[xf])               n[xf] = wv[xf];
      if (we[xm]) n[xm] = wv[xm];
    end
    return n;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // One clock: model and design advance together, outputs compared at negedge
  task automatic cyc(input string tag);
    logic [7:0] n;
    n = model_next();
    @(posedge clk);
    m_reg = n;
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_pin;
    @(negedge clk);
    chk(tag, {tmr_run, irq_tmr, irq_ext, sfr_rdata},
        {m_reg[6], m_reg[4], m_reg[7], m_reg[5], m_reg[3], m_reg[1],
         hit() ? m_reg : 8'h00});
  endtask

  task automatic idle();
    sfr_wr = 0; sfr_bit_wr = 0; tmr_ovf = 0; ack_tmr = 0; ack_ext = 0;
    sfr_addr = 8'h88; sfr_page = 4'h0;
  endtask

  task automatic bwr(input int sel, input logic v);
    idle(); sfr_bit_wr = 1; sfr_bit_sel = sel[2:0]; sfr_bit_val = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h5eed_0093);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    sfr_addr = 8'h88;
    // R1: reset state
    chk("R1", {tmr_run, irq_tmr, irq_ext, sfr_rdata}, 32'h0);

    // R2, R4: byte write sets both run bits
    idle(); sfr_wr = 1; sfr_wdata = 8'h50; cyc("R2");
    idle(); cyc("R2");
    chk("R4", tmr_run, 2'b11);
    chk("R2", sfr_rdata, 8'h50);
    // R2: wrong address and wrong page ignored
    idle(); sfr_addr = 8'h89; sfr_wr = 1; sfr_wdata = 8'h00; cyc("R2");
    chk("R2", sfr_rdata, 8'h00);
    idle(); sfr_page = 4'h1; sfr_wr = 1; sfr_wdata = 8'h00; cyc("R2");
    idle(); cyc("R2");
    chk("R2", sfr_rdata, 8'h50);

    // R3: bit write clears only bit 6
    bwr(6, 1'b0); cyc("R3");
    idle(); cyc("R3");
    chk("R3", sfr_rdata, 8'h10);

    // R5: overflow sets, write 0 clears, ack clears
    idle(); tmr_ovf = 2'b01; cyc("R5");
    chk("R5", irq_tmr, 2'b01);
    bwr(5, 1'b0); cyc("R5");
    chk("R5", irq_tmr, 2'b00);
    idle(); tmr_ovf = 2'b10; cyc("R5");
    idle(); ack_tmr = 2'b10; cyc("R5");
    chk("R5", irq_tmr, 2'b00);

    // R6: overflow, acknowledge and software clear in one cycle
    idle(); tmr_ovf = 2'b01; ack_tmr = 2'b01; sfr_wr = 1; sfr_wdata = 8'h10; cyc("R6");
    chk("R6", irq_tmr, 2'b01);
    idle(); ack_tmr = 2'b01; cyc("R6");

    // R7, R8: edge mode on channel 0, active high
    bwr(0, 1'b1); ext_pol = 2'b11; ext_pin = 2'b00; cyc("R7");
    idle(); repeat (3) cyc("R7");
    ext_pin[0] = 1'b1; cyc("R7"); cyc("R7");
    chk("R7", irq_ext[0], 1'b0);
    cyc("R7");
    chk("R7", irq_ext[0], 1'b1);
    ack_ext = 2'b01; cyc("R8");
    idle(); repeat (4) cyc("R7");
    chk("R7", irq_ext[0], 1'b0);
    ext_pin[0] = 1'b0; repeat (3) cyc("R7");
    ext_pin[0] = 1'b1; repeat (3) cyc("R8");
    bwr(1, 1'b0); cyc("R8");
    chk("R8", irq_ext[0], 1'b0);
    // R6: edge detected while an acknowledge arrives
    idle(); ext_pin[0] = 1'b0; repeat (3) cyc("R6");
    ext_pin[0] = 1'b1; cyc("R6"); cyc("R6");
    ack_ext = 2'b01; cyc("R6");
    chk("R6", irq_ext[0], 1'b1);

    // R9, R10: level mode on channel 1, active low
    idle(); ext_pol[1] = 1'b0; ext_pin[1] = 1'b1; repeat (3) cyc("R10");
    chk("R10", irq_ext[1], 1'b0);
    ext_pin[1] = 1'b0; cyc("R9"); cyc("R9");
    chk("R9", irq_ext[1], 1'b0);
    cyc("R10");
    chk("R10", irq_ext[1], 1'b1);
    ack_ext = 2'b10; cyc("R9");
    bwr(3, 1'b0); cyc("R9");
    idle(); cyc("R9");
    chk("R9", irq_ext[1], 1'b1);
    ext_pin[1] = 1'b1; repeat (3) cyc("R9");
    chk("R9", irq_ext[1], 1'b0);

    // R11: constrained random traffic against the model
    for (int k = 0; k < 4000; k++) begin
      int r;
      r = $urandom;
      idle();
      tmr_ovf = ((r & 7) == 0) ? 2'($urandom) : 2'b00;
      ack_tmr = ((r & 56) == 0) ? 2'($urandom) : 2'b00;
      ack_ext = ((r & 448) == 0) ? 2'($urandom) : 2'b00;
      if (((r >> 9) & 7) == 0) begin
        sfr_wr = 1; sfr_wdata = 8'($urandom);
      end
      if (((r >> 12) & 7) == 0) begin
        sfr_bit_wr = 1; sfr_bit_sel = 3'($urandom); sfr_bit_val = 1'($urandom);
      end
      if (((r >> 15) & 7) == 0) sfr_addr = 8'h89;
      if (((r >> 18) & 15) == 0) sfr_page = 4'h2;
      if (((r >> 22) & 3) == 0) ext_pin = 2'($urandom);
      if (((r >> 24) & 63) == 0) ext_pol = 2'($urandom);
      cyc("R11");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule